// File: doc/BRIEF.md
# Card Bus Clock Gate and Divider

This block derives the bus clock for a memory-card host from the host's reference clock. A small register port controls it. A rate field selects a power-of-two divide of the reference. Two self-clearing strobes, one to start the clock and one to stop it, gate the output. A status flag shows whether the card clock is running.

The card clock is a register output in the reference domain, so it has no glitches by construction. The gating rules keep every pulse at its full width. The clock starts and stops only while its level is low. A stop request that arrives during a high phase waits until that phase has finished. A new rate code waits for the start of the next low phase. Before reprogramming a command, software writes the stop strobe and polls the status flag until it reads 0.

Top module: `cardclk_gen`

## Requirements
- R1: The rate register sits at word address 2. A write keeps only bits [2:0] of the write data, and a read returns the code in bits [2:0] with every higher bit 0.
- R2: While running with active code c, each high phase and each low phase of `card_clk` lasts exactly 2^c reference cycles, so the period is 2^(c+1) cycles and each step of c halves the frequency.
- R3: Writing 1 to bit 1 of the control register (word address 0) starts a stopped clock. The output begins with a full low phase. The strobe has no effect while the clock is running.
- R4: Writing 1 to bit 0 of the control register stops a running clock. Once stopped, `card_clk` stays low until the next start.
- R5: Bit 8 of the status register (word address 1) reads 1 while the card clock is enabled and 0 once it has stopped. All other status bits read 0.
- R6: The control register keeps no state and always reads back as 0.
- R7: When the start and stop bits are written together, stop wins: a stopped clock stays stopped and a running clock stops.
- R8: A stop request made during a high phase lets that high phase run to its full length. The clock then stops on the falling edge.
- R9: A write to the rate register takes effect at the start of the next low phase. The low and high phases already under way keep the previous code.
- R10: After reset the clock is stopped, `card_clk` is low, and the rate code is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| card_clk | output | 1 | Gated and divided card bus clock |

## Verification
The assertions assume that `rst_n` is held low for at least one reference edge, and that each register write lasts a single cycle with stable address and data. They also assume that no read address other than 0, 1 or 2 carries meaning. The bench drives every input half a cycle or more away from the sampling edge and raises `wr_en` for exactly one cycle per write. It reads only the three defined addresses. Before it issues a start, it waits until the clock has stopped, so each queued phase length lines up with a clean start.

// File: rtl/cardclk_pkg.sv
`timescale 1ns/1ps
package cardclk_pkg;
   // word addresses of the register port
   localparam int unsigned CC_OFS_CTRL = 0;
   localparam int unsigned CC_OFS_STAT = 1;
   localparam int unsigned CC_OFS_RATE = 2;
   // control strobe positions
   localparam int unsigned CC_BIT_STOP  = 0;
   localparam int unsigned CC_BIT_START = 1;
endpackage

// File: rtl/cardclk_regs.sv
`timescale 1ns/1ps
module cardclk_regs
   import cardclk_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned RATE_W   = 3,
   parameter int unsigned STAT_BIT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              clk_run,
   output logic [DATA_W-1:0] rd_data,
   output logic              start_wr,
   output logic              stop_wr,
   output logic [RATE_W-1:0] rate_code
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CC_OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(CC_OFS_STAT);
   localparam logic [ADDR_W-1:0] A_RATE = ADDR_W'(CC_OFS_RATE);

   logic              ctrl_hit;
   logic              rate_hit;
   logic [RATE_W-1:0] rate_q;
   logic              unused_wr_hi;

   assign ctrl_hit  = wr_en && (wr_addr == A_CTRL);
   assign rate_hit  = wr_en && (wr_addr == A_RATE);
   assign stop_wr   = ctrl_hit && wr_data[CC_BIT_STOP];
   assign start_wr  = ctrl_hit && wr_data[CC_BIT_START];
   assign rate_code = rate_q;
   assign unused_wr_hi = ^wr_data[DATA_W-1:RATE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q <= '0;
      end else if (rate_hit) begin
         rate_q <= wr_data[RATE_W-1:0];
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_STAT:  rd_data[STAT_BIT]     = clk_run;
         A_RATE:  rd_data[RATE_W-1:0]   = rate_q;
         default: rd_data               = '0;
      endcase
   end
endmodule

// File: rtl/cardclk_div.sv
`timescale 1ns/1ps
module cardclk_div #(
   parameter int unsigned RATE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [RATE_W-1:0] code,
   output logic              term
);
   localparam int unsigned NCODE = 1 << RATE_W;
   localparam int unsigned CNT_W = NCODE - 1;

   logic [CNT_W-1:0] cnt_q;
   logic [NCODE-1:0] hit;

   // one terminal-count comparator per rate code
   for (genvar g = 0; g < NCODE; g++) begin : g_term
      localparam logic [CNT_W-1:0] LAST = CNT_W'((1 << g) - 1);
      assign hit[g] = (cnt_q == LAST);
   end

   assign term = run && hit[code];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || hit[code]) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/cardclk_gate.sv
`timescale 1ns/1ps
module cardclk_gate #(
   parameter int unsigned RATE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_wr,
   input  logic              stop_wr,
   input  logic              term,
   input  logic [RATE_W-1:0] code_new,
   output logic              run_q,
   output logic              clk_q,
   output logic [RATE_W-1:0] code_q
);
   logic pend_q;
   logic stop_req;

   assign stop_req = pend_q || stop_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         clk_q  <= 1'b0;
         pend_q <= 1'b0;
         code_q <= '0;
      end else if (!run_q) begin
         pend_q <= 1'b0;
         clk_q  <= 1'b0;
         if (start_wr && !stop_wr) begin
            run_q  <= 1'b1;
            code_q <= code_new;
         end
      end else if (!clk_q && stop_req) begin
         // output already low: gate off at once
         run_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (stop_wr) pend_q <= 1'b1;
         if (term) begin
            clk_q <= ~clk_q;
            if (clk_q) begin
               // falling edge: new low phase picks up the latest code
               code_q <= code_new;
               if (stop_req) begin
                  run_q  <= 1'b0;
                  pend_q <= 1'b0;
               end
            end
         end
      end
   end
endmodule

// File: rtl/cardclk_gen.sv
`timescale 1ns/1ps
module cardclk_gen #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned RATE_W   = 3,
   parameter int unsigned STAT_BIT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              card_clk
);
   if (DATA_W <= STAT_BIT) begin : g_bad_stat
      $error("cardclk_gen: STAT_BIT must lie inside DATA_W");
   end
   if (RATE_W < 2 || RATE_W > 4) begin : g_bad_rate
      $error("cardclk_gen: RATE_W must be 2 to 4");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("cardclk_gen: ADDR_W must reach three registers");
   end

   logic              start_wr;
   logic              stop_wr;
   logic              clk_run;
   logic              term;
   logic [RATE_W-1:0] rate_code;
   logic [RATE_W-1:0] code_act;

   cardclk_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RATE_W(RATE_W), .STAT_BIT(STAT_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .clk_run(clk_run),
      .rd_data(rd_data), .start_wr(start_wr), .stop_wr(stop_wr),
      .rate_code(rate_code)
   );

   cardclk_div #(.RATE_W(RATE_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(clk_run), .code(code_act), .term(term)
   );

   cardclk_gate #(.RATE_W(RATE_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .stop_wr(stop_wr),
      .term(term), .code_new(rate_code), .run_q(clk_run),
      .clk_q(card_clk), .code_q(code_act)
   );
endmodule

// File: rtl/cardclk_gen_chk.sv
`timescale 1ns/1ps
module cardclk_gen_chk
   import cardclk_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned RATE_W   = 3,
   parameter int unsigned STAT_BIT = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              stop_bit,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              card_clk,
   input logic              clk_run
);
   AST_OFF_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_run |-> !card_clk);                                        // R4
   AST_START_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_run) |-> !card_clk);                                  // R3
   AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(CC_OFS_CTRL) && stop_bit && !clk_run)
      |=> !clk_run);                                                  // R7
   AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(CC_OFS_CTRL)) |-> (rd_data == '0));          // R6
   AST_RATE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(CC_OFS_RATE)) |-> (rd_data[DATA_W-1:RATE_W] == '0)); // R1
   AST_STATUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(CC_OFS_STAT)) |-> ($countones(rd_data) == (clk_run ? 1 : 0))); // R5
endmodule

bind cardclk_gen cardclk_gen_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RATE_W(RATE_W), .STAT_BIT(STAT_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .stop_bit(wr_data[0]), .rd_addr(rd_addr), .rd_data(rd_data),
   .card_clk(card_clk), .clk_run(clk_run)
);

// File: tb/cardclk_gen_test.sv
`timescale 1ns/1ps
module cardclk_gen_test;
   localparam int DW = 32;
   localparam int AW = 2;
   localparam logic [AW-1:0] A_CTRL = 2'd0;
   localparam logic [AW-1:0] A_STAT = 2'd1;
   localparam logic [AW-1:0] A_RATE = 2'd2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] wr_data = '0;
   wire  [DW-1:0] rd_data;
   wire           card_clk;

   int    n_run = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   int    q_len[$];
   string q_tag[$];
   int    mon_cnt = 0;
   logic  mon_last = 1'b0;
   int    mon_e;
   string mon_t;
   logic [31:0] v;

   always #5 clk = ~clk;

   cardclk_gen uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .card_clk(card_clk)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: measures each card_clk phase and checks it against the queue
   always @(negedge clk) begin
      if (!rst_n) begin
         mon_cnt  = 0;
         mon_last = 1'b0;
      end else if (card_clk !== mon_last) begin
         if (q_len.size() > 0) begin
            mon_e = q_len.pop_front();
            mon_t = q_tag.pop_front();
            check(mon_t, mon_cnt, mon_e);
         end
         mon_cnt  = 1;
         mon_last = card_clk;
      end else begin
         mon_cnt++;
      end
   end

   task automatic push(input int len, input string tag, input int n);
      for (int i = 0; i < n; i++) begin
         q_len.push_back(len);
         q_tag.push_back(tag);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] val);
      rd_addr = a;
      @(negedge clk);
      val = rd_data;
   endtask

   task automatic start_clk();
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = A_CTRL; wr_data = 32'h2;
      @(negedge clk); #1;
      mon_cnt = 0;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic drain();
      while (q_len.size() != 0) @(posedge clk);
   endtask

   task automatic hold_low(input string tag, input int n);
      int bad = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (card_clk !== 1'b0) bad++;
      end
      check(tag, bad, 0);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R10 reset state
      rd(A_CTRL, v); check("R10 ctrl", v, 0);
      rd(A_STAT, v); check("R10 status", v, 0);
      rd(A_RATE, v); check("R10 rate", v, 0);
      check("R10 card_clk", {31'd0, card_clk}, 0);

      // R1 only the low three bits are kept
      wr(A_RATE, 32'hFFFF_FFFD); rd(A_RATE, v); check("R1 rate FD", v, 5);
      wr(A_RATE, 32'h0000_00FF); rd(A_RATE, v); check("R1 rate FF", v, 7);

      // R2/R3 code 0: every phase one cycle
      wr(A_RATE, 0);
      push(1, "R3 first low", 1);
      push(1, "R2 code0", 5);
      start_clk();
      drain();
      rd(A_CTRL, v); check("R6 ctrl after start", v, 0);
      rd(A_STAT, v); check("R5 status running", v, 32'h100);

      // R3 start while running has no effect
      wr(A_CTRL, 32'h2);
      push(1, "R3 start ignored", 4);
      drain();
      rd(A_STAT, v); check("R3 still running", v, 32'h100);

      // R4 stop
      wr(A_CTRL, 32'h1);
      repeat (2) @(negedge clk);
      rd(A_STAT, v); check("R4 stopped status", v, 0);
      hold_low("R4 held low", 20);

      // R2/R9 code 2 then rate change to 4 mid-run
      wr(A_RATE, 2);
      push(4, "R3 first low", 1);
      push(4, "R2 code2", 3);
      start_clk();
      drain();
      wr(A_RATE, 4);
      push(4, "R9 old low", 1);
      push(4, "R9 old high", 1);
      push(16, "R9 new code", 2);
      drain();
      rd(A_RATE, v); check("R1 rate readback", v, 4);

      // R8 stop requested during a high phase
      while (card_clk !== 1'b1) @(negedge clk);
      push(16, "R8 full high", 1);
      wr(A_CTRL, 32'h1);
      rd(A_STAT, v); check("R8 running during high", v, 32'h100);
      check("R8 still high", {31'd0, card_clk}, 1);
      while (card_clk !== 1'b0) @(negedge clk);
      rd(A_STAT, v); check("R8 stopped after fall", v, 0);
      hold_low("R8 held low", 40);
      check("R8 queue drained", q_len.size(), 0);

      // R4 stop during the first low phase
      wr(A_RATE, 3);
      start_clk();
      rd(A_STAT, v); check("R5 running after start", v, 32'h100);
      check("R3 starts low", {31'd0, card_clk}, 0);
      wr(A_CTRL, 32'h1);
      rd(A_STAT, v); check("R4 stop in low", v, 0);
      hold_low("R4 no rise", 30);

      // R7 both strobes while stopped
      wr(A_CTRL, 32'h3);
      rd(A_STAT, v); check("R7 stays stopped", v, 0);
      hold_low("R7 stopped low", 20);

      // R7 both strobes while running
      wr(A_RATE, 1);
      start_clk();
      repeat (5) @(negedge clk);
      rd(A_STAT, v); check("R7 running before", v, 32'h100);
      wr(A_CTRL, 32'h3);
      repeat (4) @(negedge clk);
      rd(A_STAT, v); check("R7 stop wins", v, 0);
      hold_low("R7 held low", 10);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule